// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache with Narrow-Port Burst Fill

This block is a read-only instruction cache that sits between a fetch unit and a narrow external memory port. It holds 8 KB as 512 direct-mapped lines of 16 bytes. Each line has one tag and one valid flag, and lookup uses the physical fetch address. A fetch that hits returns its 16-bit instruction word on the next clock. A fetch that misses stalls the fetch port while the block reads the whole line as a burst. The burst runs over either a 16-bit or an 8-bit external port. The block then answers the stalled fetch in the cycle after the final beat.

The core offers a fetch with `fetch_req` and `fetch_addr`, and the fetch is taken in any cycle where `fetch_ready` is high. The external side holds `mem_req` high together with a line-aligned `mem_addr` for the length of one burst. Memory returns beats on `mem_beat_valid`/`mem_beat_data`, and it may leave idle cycles between beats. A one-cycle pulse on `inval_req` empties the whole cache. The block does this by clearing one line per clock, and fetches are held off until the sweep is done.

Top module: `icache_dm_top`

## Requirements
- R1: After reset every line is invalid, `fetch_ready` is 1, `rsp_valid` is 0 and `mem_req` is 0.
- R2: The fetch address is split as follows: bits [3:0] pick the byte in a line, bits [12:4] pick one of 512 lines, and bits [31:13] are the tag. On a miss, `mem_req` is high in the cycle after the fetch is taken. `mem_addr` equals the fetch address with bits [3:0] cleared and stays unchanged while `mem_req` is high.
- R3: A fetch that hits drives `rsp_valid` high one cycle after it is taken, with the correct word. It starts no burst. `fetch_ready` stays high, so fetches can be issued back to back.
- R4: When `byte_port`=0, each beat carries 16 bits and a line takes 8 beats. When `byte_port`=1, each beat carries 8 bits on `mem_beat_data[7:0]` and a line takes 16 beats. A beat is any cycle in which `mem_beat_valid` and `mem_req` are both high.
- R5: The line is big-endian. The first byte received is byte 0 of the line, and within a 16-bit beat bits [15:8] belong to the lower address. `rsp_word[15:8]` is the byte at the fetch address with bit 0 cleared, and `rsp_word[7:0]` is the byte after it. Fetch address bit 0 is ignored.
- R6: The clock edge that takes the last beat writes the line and sets its valid flag. That edge also makes `rsp_valid` high in the next cycle with the requested word. No response appears before that edge.
- R7: A fetch whose line index matches a valid line but whose tag differs is a miss. Its fill replaces the old line, so the old address misses afterwards.
- R8: If `inval_req` is high in a cycle where the cache is idle, `fetch_ready` is low in that cycle and in the following 512 cycles. After that, every earlier line misses.
- R9: If `inval_req` is high during a fill, it is remembered. The fill completes and is answered, and a 512-cycle sweep then follows, so the line just filled is invalid afterwards.
- R10: `byte_port` is sampled only when a missing fetch is taken. Changing it during a burst has no effect on the beat count or the data.
- R11: `fetch_ready` stays low for the whole fill. A `fetch_req` raised during the fill is ignored and leads to no response and no further burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req | input | 1 | Fetch request from the core |
| fetch_addr | input | 32 | Physical fetch byte address |
| fetch_ready | output | 1 | A fetch is taken in this cycle if requested |
| rsp_valid | output | 1 | Instruction word valid |
| rsp_word | output | 16 | Instruction word, big-endian |
| inval_req | input | 1 | Request to invalidate the whole cache |
| byte_port | input | 1 | 1: 8-bit external port, 0: 16-bit external port |
| mem_req | output | 1 | Burst in progress |
| mem_addr | output | 32 | Line-aligned burst address |
| mem_beat_valid | input | 1 | Memory beat present |
| mem_beat_data | input | 16 | Memory beat data |

## Verification
The assertions assume that memory drives `mem_beat_valid` only while `mem_req` is high and returns the beats of a line in address order. They also assume that `inval_req` is a short pulse and not a level held through a sweep. The stimulus respects these limits. Its memory model starts a burst only when it sees `mem_req`, and it stops driving beats once `mem_req` falls. It inserts a fixed pattern of idle cycles between beats. It pulses `inval_req` for exactly one cycle, both in an idle cycle and in the middle of a fill.

// File: rtl/icache_pkg.sv
package icache_pkg;

    localparam int unsigned ADDR_W_DEF     = 32;
    localparam int unsigned LINE_BYTES_DEF = 16;
    localparam int unsigned NUM_LINES_DEF  = 512;
    localparam int unsigned WORD_W         = 16;
    localparam int unsigned BUS_W          = 16;

    typedef enum logic [1:0] {
        CS_IDLE  = 2'd0,
        CS_FILL  = 2'd1,
        CS_SWEEP = 2'd2
    } ctl_state_e;

    typedef enum logic {
        PORT_WIDE = 1'b0,
        PORT_BYTE = 1'b1
    } port_mode_e;

    // Number of beats needed to move one line over the selected port width.
    function automatic int unsigned beats_per_line(input port_mode_e m,
                                                   input int unsigned line_bytes,
                                                   input int unsigned bus_bytes);
        return (m == PORT_BYTE) ? line_bytes : line_bytes / bus_bytes;
    endfunction

endpackage

// File: rtl/icache_tag_ram.sv
module icache_tag_ram #(
    parameter int unsigned NUM_LINES = 512,
    parameter int unsigned TAG_W     = 19,
    localparam int unsigned IDX_W    = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_valid,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx
);

    logic [NUM_LINES-1:0] valid_q;
    logic [TAG_W-1:0]     tag_q [NUM_LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else begin
            if (wr_en)  valid_q[wr_idx]  <= 1'b1;
            if (clr_en) valid_q[clr_idx] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) tag_q[wr_idx] <= wr_tag;
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];

    // Last-write trackers used by the checks below.
    logic             wr_seen_q, clr_seen_q;
    logic [IDX_W-1:0] wr_idx_q, clr_idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_seen_q  <= 1'b0;
            clr_seen_q <= 1'b0;
            wr_idx_q   <= '0;
            clr_idx_q  <= '0;
        end else begin
            wr_seen_q  <= wr_en;
            clr_seen_q <= clr_en;
            wr_idx_q   <= wr_idx;
            clr_idx_q  <= clr_idx;
        end
    end

    p_fill_sets_valid_r6: assert property (@(posedge clk) disable iff (rst)
        wr_seen_q |-> valid_q[wr_idx_q]);

    p_sweep_clears_line_r8: assert property (@(posedge clk) disable iff (rst)
        clr_seen_q |-> !valid_q[clr_idx_q]);

    p_write_clear_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && clr_en));

endmodule

// File: rtl/icache_data_ram.sv
module icache_data_ram #(
    parameter int unsigned NUM_LINES = 512,
    parameter int unsigned LINE_W    = 128,
    localparam int unsigned IDX_W    = $clog2(NUM_LINES)
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [LINE_W-1:0] rd_line,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [LINE_W-1:0] wr_line
);

    logic [LINE_W-1:0] line_q [NUM_LINES];

    always_ff @(posedge clk) begin
        if (wr_en) line_q[wr_idx] <= wr_line;
    end

    assign rd_line = line_q[rd_idx];

endmodule

// File: rtl/icache_fill_ctrl.sv
module icache_fill_ctrl
    import icache_pkg::*;
#(
    parameter int unsigned LINE_BYTES = 16,
    parameter int unsigned BUS_BYTES  = 2,
    localparam int unsigned LINE_W    = 8 * LINE_BYTES,
    localparam int unsigned BEAT_W    = 8 * BUS_BYTES,
    localparam int unsigned CNT_W     = $clog2(LINE_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              byte_mode,
    input  logic              beat_valid,
    input  logic [BEAT_W-1:0] beat_data,
    output logic              busy,
    output logic              done,
    output logic [LINE_W-1:0] line_next
);

    port_mode_e        mode_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [LINE_W-1:0] buf_q;
    logic [CNT_W-1:0]  last_cnt;
    logic              last_beat;

    // Bytes enter at the bottom and move up, so the first byte ends at the top (big-endian).
    always_comb begin
        if (mode_q == PORT_BYTE) begin
            line_next = {buf_q[LINE_W-9:0], beat_data[7:0]};
        end else begin
            line_next = {buf_q[LINE_W-BEAT_W-1:0], beat_data};
        end
        last_cnt  = CNT_W'(beats_per_line(mode_q, LINE_BYTES, BUS_BYTES) - 1);
        last_beat = (cnt_q == last_cnt);
    end

    assign done = busy && beat_valid && last_beat;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            cnt_q  <= '0;
            mode_q <= PORT_WIDE;
            buf_q  <= '0;
        end else if (start && !busy) begin
            busy   <= 1'b1;
            cnt_q  <= '0;
            mode_q <= port_mode_e'(byte_mode);
        end else if (busy && beat_valid) begin
            buf_q <= line_next;
            cnt_q <= cnt_q + 1'b1;
            if (last_beat) busy <= 1'b0;
        end
    end

    p_start_only_when_free_r11: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);

    p_mode_held_in_burst_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(mode_q));

    p_done_ends_burst_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

endmodule

// File: rtl/icache_dm_top.sv
module icache_dm_top
    import icache_pkg::*;
#(
    parameter int unsigned ADDR_W     = ADDR_W_DEF,
    parameter int unsigned LINE_BYTES = LINE_BYTES_DEF,
    parameter int unsigned NUM_LINES  = NUM_LINES_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_ready,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_word,
    input  logic              inval_req,
    input  logic              byte_port,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_beat_valid,
    input  logic [BUS_W-1:0]  mem_beat_data
);

    localparam int unsigned OFF_W  = $clog2(LINE_BYTES);
    localparam int unsigned IDX_W  = $clog2(NUM_LINES);
    localparam int unsigned TAG_W  = ADDR_W - OFF_W - IDX_W;
    localparam int unsigned LINE_W = 8 * LINE_BYTES;
    localparam int unsigned BSEL_W = $clog2(WORD_W / 8);
    localparam int unsigned WSEL_W = OFF_W - BSEL_W;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [IDX_W-1:0]  idx;
        logic [WSEL_W-1:0] wsel;
    } line_ref_t;

    function automatic logic [WORD_W-1:0] pick_word(input logic [LINE_W-1:0] line,
                                                    input logic [WSEL_W-1:0] ws);
        logic [LINE_W-1:0] sh;
        sh = line << (ws * WORD_W);
        return sh[LINE_W-1 -: WORD_W];
    endfunction

    line_ref_t  req_ref, miss_q;
    ctl_state_e state_q;
    logic       inval_pend_q;
    logic [IDX_W-1:0] swp_idx_q;
    logic       unused_lsb;

    logic [TAG_W-1:0]  rd_tag;
    logic              rd_valid;
    logic [LINE_W-1:0] rd_line, fill_line;
    logic              hit, accept, fill_start, fill_busy, fill_done, sweep_last;

    assign req_ref    = line_ref_t'(fetch_addr[ADDR_W-1:BSEL_W]);
    assign unused_lsb = ^fetch_addr[BSEL_W-1:0];

    assign fetch_ready = (state_q == CS_IDLE) && !inval_req;
    assign accept      = fetch_req && fetch_ready;
    assign hit         = rd_valid && (rd_tag == req_ref.tag);
    assign fill_start  = accept && !hit;
    assign sweep_last  = (swp_idx_q == IDX_W'(NUM_LINES - 1));

    icache_tag_ram #(
        .NUM_LINES (NUM_LINES),
        .TAG_W     (TAG_W)
    ) tags_i (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (req_ref.idx),
        .rd_tag   (rd_tag),
        .rd_valid (rd_valid),
        .wr_en    (fill_done),
        .wr_idx   (miss_q.idx),
        .wr_tag   (miss_q.tag),
        .clr_en   (state_q == CS_SWEEP),
        .clr_idx  (swp_idx_q)
    );

    icache_data_ram #(
        .NUM_LINES (NUM_LINES),
        .LINE_W    (LINE_W)
    ) data_i (
        .clk     (clk),
        .rd_idx  (req_ref.idx),
        .rd_line (rd_line),
        .wr_en   (fill_done),
        .wr_idx  (miss_q.idx),
        .wr_line (fill_line)
    );

    icache_fill_ctrl #(
        .LINE_BYTES (LINE_BYTES),
        .BUS_BYTES  (BUS_W / 8)
    ) fill_i (
        .clk        (clk),
        .rst        (rst),
        .start      (fill_start),
        .byte_mode  (byte_port),
        .beat_valid (mem_beat_valid),
        .beat_data  (mem_beat_data),
        .busy       (fill_busy),
        .done       (fill_done),
        .line_next  (fill_line)
    );

    assign mem_req  = fill_busy;
    assign mem_addr = {miss_q.tag, miss_q.idx, {OFF_W{1'b0}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= CS_IDLE;
            miss_q       <= '0;
            inval_pend_q <= 1'b0;
            swp_idx_q    <= '0;
            rsp_valid    <= 1'b0;
            rsp_word     <= '0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (state_q)
                CS_IDLE: begin
                    if (inval_req) begin
                        state_q      <= CS_SWEEP;
                        swp_idx_q    <= '0;
                        inval_pend_q <= 1'b0;
                    end else if (accept) begin
                        if (hit) begin
                            rsp_valid <= 1'b1;
                            rsp_word  <= pick_word(rd_line, req_ref.wsel);
                        end else begin
                            miss_q  <= req_ref;
                            state_q <= CS_FILL;
                        end
                    end
                end
                CS_FILL: begin
                    if (inval_req) inval_pend_q <= 1'b1;
                    if (fill_done) begin
                        rsp_valid <= 1'b1;
                        rsp_word  <= pick_word(fill_line, miss_q.wsel);
                        if (inval_pend_q || inval_req) begin
                            state_q      <= CS_SWEEP;
                            swp_idx_q    <= '0;
                            inval_pend_q <= 1'b0;
                        end else begin
                            state_q <= CS_IDLE;
                        end
                    end
                end
                CS_SWEEP: begin
                    swp_idx_q <= swp_idx_q + 1'b1;
                    if (sweep_last) state_q <= CS_IDLE;
                end
                default: state_q <= CS_IDLE;
            endcase
        end
    end

    p_hit_answers_next_r3: assert property (@(posedge clk) disable iff (rst)
        (accept && hit) |=> rsp_valid);

    p_burst_addr_stable_r2: assert property (@(posedge clk) disable iff (rst)
        (mem_req && $past(mem_req)) |-> $stable(mem_addr));

    p_no_early_rsp_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == CS_FILL && !fill_done) |=> !rsp_valid);

    p_sweep_runs_on_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == CS_SWEEP && !sweep_last) |=> (state_q == CS_SWEEP));

    p_stall_in_fill_r11: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !fetch_ready);

endmodule

// File: tb/icache_dm_top_tb.sv
module icache_dm_top_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        fetch_req;
    logic [31:0] fetch_addr;
    logic        fetch_ready;
    logic        rsp_valid;
    logic [15:0] rsp_word;
    logic        inval_req;
    logic        byte_port;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_beat_valid;
    logic [15:0] mem_beat_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // Reference state: behavioural tag/valid model and memory responder bookkeeping.
    bit          mvalid [512];
    logic [18:0] mtag   [512];
    bit          exp_byte_mode = 1'b0;
    bit          rsp_active = 1'b0;
    int          rsp_pos = 0;
    int          beats_given = 0;
    int          gap_ctr = 0;
    int          last_beat_cyc = 0;
    logic [31:0] burst_addr = '0;

    icache_dm_top dut_i (
        .clk            (clk),
        .rst            (rst),
        .fetch_req      (fetch_req),
        .fetch_addr     (fetch_addr),
        .fetch_ready    (fetch_ready),
        .rsp_valid      (rsp_valid),
        .rsp_word       (rsp_word),
        .inval_req      (inval_req),
        .byte_port      (byte_port),
        .mem_req        (mem_req),
        .mem_addr       (mem_addr),
        .mem_beat_valid (mem_beat_valid),
        .mem_beat_data  (mem_beat_data)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] mb(input logic [31:0] a);
        return (a[7:0] * 8'd13) ^ (a[15:8] * 8'd7) ^ a[23:16] ^ a[31:24] ^ 8'h3C;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Memory responder: beats only while mem_req, one idle cycle in every three.
    always @(negedge clk) begin
        if (rst || !mem_req) begin
            mem_beat_valid = 1'b0;
            rsp_active     = 1'b0;
        end else begin
            if (!rsp_active) begin
                rsp_active  = 1'b1;
                rsp_pos     = 0;
                beats_given = 0;
                burst_addr  = mem_addr;
            end
            if (gap_ctr % 3 == 2) begin
                mem_beat_valid = 1'b0;
            end else begin
                mem_beat_valid = 1'b1;
                beats_given++;
                last_beat_cyc = cyc;
                if (rsp_pos >= 16) begin
                    mem_beat_data = 16'hDEAD;
                end else if (exp_byte_mode) begin
                    mem_beat_data = {8'hEE, mb(burst_addr + 32'(rsp_pos))};
                    rsp_pos += 1;
                end else begin
                    mem_beat_data = {mb(burst_addr + 32'(rsp_pos)), mb(burst_addr + 32'(rsp_pos) + 32'd1)};
                    rsp_pos += 2;
                end
            end
            gap_ctr++;
        end
    end

    task automatic model_clear();
        for (int i = 0; i < 512; i++) mvalid[i] = 1'b0;
    endtask

    task automatic do_fetch(input logic [31:0] a);
        logic [8:0]  idx;
        logic [18:0] t;
        bit          exp_hit;
        logic [15:0] exp_w;
        idx     = a[12:4];
        t       = a[31:13];
        exp_hit = mvalid[idx] && (mtag[idx] == t);
        exp_w   = {mb({a[31:1], 1'b0}), mb({a[31:1], 1'b1})};
        while (!fetch_ready) @(negedge clk);
        exp_byte_mode = byte_port;
        fetch_req  = 1'b1;
        fetch_addr = a;
        @(negedge clk);
        fetch_req = 1'b0;
        if (exp_hit) begin
            check(rsp_valid == 1'b1, "R3", "hit rsp_valid", 32'(rsp_valid), 32'd1);
            check(rsp_word == exp_w, "R5", "hit word", 32'(rsp_word), 32'(exp_w));
            check(mem_req == 1'b0, "R3", "hit starts no burst", 32'(mem_req), 32'd0);
        end else begin
            check(rsp_valid == 1'b0 && mem_req == 1'b1, "R2", "miss starts burst",
                  {15'd0, rsp_valid, 15'd0, mem_req}, 32'd1);
            check(mem_addr == {a[31:4], 4'b0}, "R2", "burst address", mem_addr, {a[31:4], 4'b0});
            while (!rsp_valid) @(negedge clk);
            check(cyc == last_beat_cyc + 1, "R6", "rsp after last beat", 32'(cyc), 32'(last_beat_cyc + 1));
            check(rsp_word == exp_w, "R5", "fill word", 32'(rsp_word), 32'(exp_w));
            check(beats_given == (exp_byte_mode ? 16 : 8), "R4", "beats per line",
                  32'(beats_given), exp_byte_mode ? 32'd16 : 32'd8);
            mvalid[idx] = 1'b1;
            mtag[idx]   = t;
        end
    endtask

    task automatic count_stall(input int exp_n, input string req);
        int n;
        n = 0;
        while (!fetch_ready) begin
            n++;
            @(negedge clk);
        end
        check(n == exp_n, req, "sweep stall cycles", 32'(n), 32'(exp_n));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; fetch_req = 1'b0; fetch_addr = '0; inval_req = 1'b0;
        byte_port = 1'b0; mem_beat_valid = 1'b0; mem_beat_data = '0;
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        check(fetch_ready == 1'b1, "R1", "ready after reset", 32'(fetch_ready), 32'd1);
        check(rsp_valid == 1'b0, "R1", "no rsp after reset", 32'(rsp_valid), 32'd0);
        check(mem_req == 1'b0, "R1", "no burst after reset", 32'(mem_req), 32'd0);
        @(negedge clk);

        // R2/R4/R6: wide-port miss, then every word of the line hits (R3, R5)
        do_fetch(32'h0000_1236);
        for (int w = 0; w < 8; w++) do_fetch(32'h0000_1230 + 32'(2 * w));
        do_fetch(32'h0000_1233);  // R5: address bit 0 ignored

        // R3: back-to-back hits
        fetch_req = 1'b1; fetch_addr = 32'h0000_1234;
        @(negedge clk);
        check(rsp_valid && rsp_word == {mb(32'h1234), mb(32'h1235)}, "R3", "b2b first",
              32'(rsp_word), 32'({mb(32'h1234), mb(32'h1235)}));
        check(fetch_ready == 1'b1, "R3", "ready during hits", 32'(fetch_ready), 32'd1);
        fetch_addr = 32'h0000_123C;
        @(negedge clk);
        fetch_req = 1'b0;
        check(rsp_valid && rsp_word == {mb(32'h123C), mb(32'h123D)}, "R3", "b2b second",
              32'(rsp_word), 32'({mb(32'h123C), mb(32'h123D)}));

        // R4: byte-wide port
        byte_port = 1'b1;
        do_fetch(32'h0004_567A);
        do_fetch(32'h0004_5670);
        byte_port = 1'b0;

        // R10: port width changes mid-burst are ignored
        fork
            do_fetch(32'h0008_0104);
            begin repeat (3) @(negedge clk); byte_port = 1'b1; end
        join
        byte_port = 1'b0;
        do_fetch(32'h0008_010E);

        // R7: same index, different tag evicts
        do_fetch(32'h0000_3230);
        do_fetch(32'h0000_3230);
        do_fetch(32'h0000_1230);

        // R11: request during fill is ignored
        fork
            do_fetch(32'h0010_0040);
            begin
                repeat (3) @(negedge clk);
                check(fetch_ready == 1'b0, "R11", "stalled during fill", 32'(fetch_ready), 32'd0);
                fetch_req = 1'b1; fetch_addr = 32'h0000_5550;
                @(negedge clk);
                fetch_req = 1'b0;
            end
        join
        @(negedge clk);
        check(rsp_valid == 1'b0 && mem_req == 1'b0, "R11", "ignored request left no trace",
              {15'd0, rsp_valid, 15'd0, mem_req}, 32'd0);

        // R8: idle invalidate sweep
        while (!fetch_ready) @(negedge clk);
        inval_req = 1'b1;
        #1;
        check(fetch_ready == 1'b0, "R8", "ready low with inval", 32'(fetch_ready), 32'd0);
        @(negedge clk);
        inval_req = 1'b0;
        count_stall(512, "R8");
        model_clear();
        do_fetch(32'h0000_1230);
        do_fetch(32'h0004_5670);

        // R9: invalidate raised during a fill
        fork
            do_fetch(32'h0020_0050);
            begin
                repeat (3) @(negedge clk);
                inval_req = 1'b1;
                @(negedge clk);
                inval_req = 1'b0;
            end
        join
        count_stall(512, "R9");
        model_clear();
        do_fetch(32'h0020_0050);

        // Top tag bits
        do_fetch(32'hFFFF_FFF2);
        do_fetch(32'hFFFF_FFFE);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule